// File: doc/BRIEF.md
# Synchronized Transfer Request Sequencer

This block paces a three-dimensional transfer. The transfer is described by an array length, an arrays-per-frame count and a frame count. An arm pulse loads these counts, a sync mode, a 6-bit completion code and two report enables. After that, each sync strobe releases exactly one transfer request.

In array-sync mode a request covers one array, so a run takes arrays-per-frame × frames requests. In frame-sync mode a request covers a whole frame, so a run takes one request per frame. Every request is followed, a fixed number of cycles later, by a completion report. The report is tagged final for the last request of the run and intermediate for all the others. It is reported only if the matching enable was set at arm time, and it carries the stored code, which has no tie to any channel number.

A run in which any count is zero is null: it issues nothing. Sync strobes that arrive while no run is active are dropped. Data movement and address generation belong to the surrounding engine.

Top module: `srq_seq`

## Requirements
- R1: While reset is held and right after it is released, done_o is 1 and req_o, req_last_o and rpt_o are 0.
- R2: An arm_i pulse with all three counts nonzero makes done_o 0 from the next cycle. A sync_i given in the same cycle as arm_i issues no request.
- R3: Each sync_i seen while a run is active makes req_o 1 for exactly the following cycle. Exactly one request is issued per strobe.
- R4: In array-sync mode (mode_i = 0) a run issues bcnt × ccnt requests. req_last_o is 1 with the last one, and done_o is 1 in that same cycle.
- R5: In frame-sync mode (mode_i = 1) a run issues ccnt requests, whatever bcnt is.
- R6: With only the final enable set (fin_ie_i = 1, mid_ie_i = 0), a run yields exactly one report, with rpt_final_o = 1, for its last request.
- R7: With only the intermediate enable set, a run yields a report for every request except the last, each with rpt_final_o = 0.
- R8: With both enables set, every request yields a report. With neither set, no request does.
- R9: rpt_code_o equals code_i as sampled at arm time. Later changes of code_i have no effect on the run.
- R10: A report (rpt_o = 1) appears exactly RPT_LAT cycles after the req_o pulse it belongs to, and at no other time.
- R11: Sync strobes after the last request of a run produce neither a request nor a report until the next arm.
- R12: Arming with acnt, bcnt or ccnt equal to zero leaves done_o at 1 and issues no request or report for any later sync.
- R13: Arming while a run is active abandons that run and restarts with the new counts, mode, code and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Load the run settings and start a run |
| mode_i | input | 1 | 0 = one request per array, 1 = one request per frame |
| acnt_i | input | CW | Array length in bytes (used only for the null check) |
| bcnt_i | input | CW | Arrays per frame |
| ccnt_i | input | CW | Frames per run |
| code_i | input | 6 | Completion code to report |
| fin_ie_i | input | 1 | Report the final request |
| mid_ie_i | input | 1 | Report intermediate requests |
| sync_i | input | 1 | Sync strobe |
| req_o | output | 1 | Transfer request pulse |
| req_last_o | output | 1 | Marks the last request of the run |
| rpt_o | output | 1 | Completion report pulse |
| rpt_final_o | output | 1 | Report is for the final request |
| rpt_code_o | output | 6 | Code carried by the report |
| done_o | output | 1 | No run is active |

## Verification
The bench goes after the request count at the array/frame wrap. A design that reloads the inner count wrongly issues too many or too few requests in array-sync mode, or stops early. It checks the last-request decision under every pair of enables. A swapped or merged enable gives a count such as 20 instead of 19, or an intermediate report tagged final. It aims syncs at the cycle of an arm, after the last request and after a null arm. A design that lets these through emits stray requests. It also re-arms in mid-run with a changed code. A design that keeps the old counters or samples code_i live reports the wrong count or the wrong code.

// File: rtl/srq_pkg.sv
package srq_pkg;

   localparam int CODE_W = 6;

   typedef enum logic {
      SYNC_A  = 1'b0,
      SYNC_AB = 1'b1
   } sync_mode_e;

   typedef struct packed {
      logic              vld;
      logic              fin;
      logic [CODE_W-1:0] code;
   } rpt_t;

endpackage

// File: rtl/srq_dim_cnt.sv
// Down counter for one transfer dimension: loaded at arm, reloaded on wrap.
module srq_dim_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic [CW-1:0] reload_val_i,
   input  logic          step_i,
   output logic [CW-1:0] cnt_o,
   output logic          is_one_o
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;

   assign is_one_o = (cnt_q == ONE);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (step_i) begin
         if (is_one_o) cnt_q <= reload_val_i;
         else          cnt_q <= cnt_q - ONE;
      end
   end

endmodule

// File: rtl/srq_cfg_reg.sv
// Run settings captured at arm time.
module srq_cfg_reg
   import srq_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              mode_i,
   input  logic [CW-1:0]     bcnt_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              fin_ie_i,
   input  logic              mid_ie_i,
   output sync_mode_e        mode_o,
   output logic [CW-1:0]     bcnt_o,
   output logic [CODE_W-1:0] code_o,
   output logic              fin_ie_o,
   output logic              mid_ie_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_o   <= SYNC_A;
         bcnt_o   <= '0;
         code_o   <= '0;
         fin_ie_o <= 1'b0;
         mid_ie_o <= 1'b0;
      end else if (load_i) begin
         mode_o   <= sync_mode_e'(mode_i);
         bcnt_o   <= bcnt_i;
         code_o   <= code_i;
         fin_ie_o <= fin_ie_i;
         mid_ie_o <= mid_ie_i;
      end
   end

endmodule

// File: rtl/srq_rpt_pipe.sv
// Fixed-latency delay line from request stage to completion report.
module srq_rpt_pipe
   import srq_pkg::*;
#(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  rpt_t d_i,
   output rpt_t q_o
);

   generate
      if (LAT == 1) begin : g_single
         rpt_t r_q;
         always_ff @(posedge clk) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= d_i;
         end
         assign q_o = r_q;
      end else begin : g_chain
         rpt_t st_q [LAT];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LAT; i++) st_q[i] <= '0;
            end else begin
               st_q[0] <= d_i;
               for (int i = 1; i < LAT; i++) st_q[i] <= st_q[i-1];
            end
         end
         assign q_o = st_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/srq_seq.sv
module srq_seq
   import srq_pkg::*;
#(
   parameter int CW      = 16,
   parameter int RPT_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              mode_i,
   input  logic [CW-1:0]     acnt_i,
   input  logic [CW-1:0]     bcnt_i,
   input  logic [CW-1:0]     ccnt_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              fin_ie_i,
   input  logic              mid_ie_i,
   input  logic              sync_i,
   output logic              req_o,
   output logic              req_last_o,
   output logic              rpt_o,
   output logic              rpt_final_o,
   output logic [CODE_W-1:0] rpt_code_o,
   output logic              done_o
);

   localparam int NDIM  = 2;   // index 0: arrays in a frame, 1: frames
   localparam int DIM_B = 0;
   localparam int DIM_C = 1;

   generate
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("srq_seq: CW must lie in 2..32");
      end
      if (RPT_LAT < 1 || RPT_LAT > 8) begin : g_bad_lat
         $error("srq_seq: RPT_LAT must lie in 1..8");
      end
   endgenerate

   // settings
   sync_mode_e        cfg_mode;
   logic [CW-1:0]     cfg_bcnt;
   logic [CODE_W-1:0] cfg_code;
   logic              cfg_fin, cfg_mid;

   srq_cfg_reg #(.CW(CW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (arm_i),
      .mode_i   (mode_i),
      .bcnt_i   (bcnt_i),
      .code_i   (code_i),
      .fin_ie_i (fin_ie_i),
      .mid_ie_i (mid_ie_i),
      .mode_o   (cfg_mode),
      .bcnt_o   (cfg_bcnt),
      .code_o   (cfg_code),
      .fin_ie_o (cfg_fin),
      .mid_ie_o (cfg_mid)
   );

   // run control
   logic active_q;
   logic fire, last;
   logic cnt_ok;

   assign cnt_ok = (|acnt_i) & (|bcnt_i) & (|ccnt_i);
   assign fire   = active_q & sync_i & ~arm_i;

   // dimension counters
   logic [CW-1:0] dim_load  [NDIM];
   logic [CW-1:0] dim_rel   [NDIM];
   logic          dim_step  [NDIM];
   logic [CW-1:0] dim_cnt   [NDIM];
   logic          dim_one   [NDIM];

   assign dim_load[DIM_B] = bcnt_i;
   assign dim_rel [DIM_B] = cfg_bcnt;
   assign dim_step[DIM_B] = fire & (cfg_mode == SYNC_A);
   assign dim_load[DIM_C] = ccnt_i;
   assign dim_rel [DIM_C] = '0;
   assign dim_step[DIM_C] = fire & ((cfg_mode == SYNC_AB) | dim_one[DIM_B]);

   generate
      for (genvar d = 0; d < NDIM; d++) begin : g_dim
         srq_dim_cnt #(.CW(CW)) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (arm_i),
            .load_val_i   (dim_load[d]),
            .reload_val_i (dim_rel[d]),
            .step_i       (dim_step[d]),
            .cnt_o        (dim_cnt[d]),
            .is_one_o     (dim_one[d])
         );
      end
   endgenerate

   logic [CW-1:0] frames_left;
   assign frames_left = dim_cnt[DIM_C];

   always_comb begin
      if (cfg_mode == SYNC_AB) last = dim_one[DIM_C];
      else                     last = dim_one[DIM_B] & dim_one[DIM_C];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
      end else if (arm_i) begin
         active_q <= cnt_ok;
      end else if (fire && last) begin
         active_q <= 1'b0;
      end
   end

   // request stage
   logic              req_q, req_last_q, rv_q;
   logic [CODE_W-1:0] rc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q      <= 1'b0;
         req_last_q <= 1'b0;
         rv_q       <= 1'b0;
         rc_q       <= '0;
      end else begin
         req_q      <= fire;
         req_last_q <= fire & last;
         rv_q       <= fire & (last ? cfg_fin : cfg_mid);
         rc_q       <= cfg_code;
      end
   end

   // report delay
   rpt_t rpt_d, rpt_q;

   assign rpt_d.vld  = rv_q;
   assign rpt_d.fin  = req_last_q;
   assign rpt_d.code = rc_q;

   srq_rpt_pipe #(.LAT(RPT_LAT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rpt_d),
      .q_o   (rpt_q)
   );

   assign req_o       = req_q;
   assign req_last_o  = req_last_q;
   assign rpt_o       = rpt_q.vld;
   assign rpt_final_o = rpt_q.vld & rpt_q.fin;
   assign rpt_code_o  = rpt_q.code;
   assign done_o      = ~active_q | (frames_left == '0);

endmodule

// File: rtl/srq_seq_chk.sv
module srq_seq_chk
   import srq_pkg::*;
#(
   parameter int CW      = 16,
   parameter int RPT_LAT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm_i,
   input logic              mode_i,
   input logic [CW-1:0]     acnt_i,
   input logic [CW-1:0]     bcnt_i,
   input logic [CW-1:0]     ccnt_i,
   input logic [CODE_W-1:0] code_i,
   input logic              fin_ie_i,
   input logic              mid_ie_i,
   input logic              sync_i,
   input logic              req_o,
   input logic              req_last_o,
   input logic              rpt_o,
   input logic              rpt_final_o,
   input logic [CODE_W-1:0] rpt_code_o,
   input logic              done_o
);

   logic [RPT_LAT-1:0] req_sh, last_sh;
   logic               zero_cnt;

   assign zero_cnt = (acnt_i == '0) | (bcnt_i == '0) | (ccnt_i == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_sh  <= '0;
         last_sh <= '0;
      end else begin
         req_sh[0]  <= req_o;
         last_sh[0] <= req_last_o;
         for (int i = 1; i < RPT_LAT; i++) begin
            req_sh[i]  <= req_sh[i-1];
            last_sh[i] <= last_sh[i-1];
         end
      end
   end

   // R3
   req_from_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> ($past(sync_i) && !$past(arm_i)));

   // R11
   no_req_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !req_o);

   // R12
   null_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && zero_cnt) |=> done_o);

   // R2
   arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && !zero_cnt) |=> !done_o);

   // R4
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ((req_o && req_last_o) || $past(arm_i)));

   // R10
   rpt_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_o |-> req_sh[RPT_LAT-1]);

   // R6
   rpt_final_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_o |-> (rpt_final_o == last_sh[RPT_LAT-1]));

endmodule

bind srq_seq srq_seq_chk #(.CW(CW), .RPT_LAT(RPT_LAT)) u_chk (.*);

// File: tb/srq_seq_test.sv
`timescale 1ns/1ps
module srq_seq_test;
   import srq_pkg::*;

   localparam int CW      = 16;
   localparam int RPT_LAT = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              arm_i = 1'b0;
   logic              mode_i = 1'b0;
   logic [CW-1:0]     acnt_i = '0, bcnt_i = '0, ccnt_i = '0;
   logic [CODE_W-1:0] code_i = '0;
   logic              fin_ie_i = 1'b0, mid_ie_i = 1'b0, sync_i = 1'b0;
   logic              req_o, req_last_o, rpt_o, rpt_final_o, done_o;
   logic [CODE_W-1:0] rpt_code_o;

   srq_seq #(.CW(CW), .RPT_LAT(RPT_LAT)) uut (.*);

   always #10 clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   int cyc = 0;

   // expected reports, indexed by cycle modulo 16
   bit          ev [16];
   bit          ef [16];
   logic [5:0]  ec [16];
   int          rpt_cnt = 0;

   // bench view of the run
   int          exp_rem = 0;
   int          req_cnt = 0;
   bit          cur_fin, cur_mid;
   logic [5:0]  cur_code;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int reqs_of(input bit m, input int a, input int b, input int c);
      if (a == 0 || b == 0 || c == 0) return 0;
      return m ? c : b * c;
   endfunction

   function automatic int rpts_of(input int n, input bit fin, input bit mid);
      if (n == 0) return 0;
      return (fin ? 1 : 0) + (mid ? n - 1 : 0);
   endfunction

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      int s;
      s = cyc % 16;
      if (rst_n && (rpt_o || ev[s])) begin
         if (rpt_o != ev[s])
            chk(1'b0, "R10 report presence", int'(rpt_o), int'(ev[s]));
         else if (rpt_final_o != ef[s])
            chk(1'b0, "R6 final tag", int'(rpt_final_o), int'(ef[s]));
         else if (rpt_code_o != ec[s])
            chk(1'b0, "R9 report code", int'(rpt_code_o), int'(ec[s]));
         else
            chk(1'b1, "R10", 0, 0);
      end
      if (rpt_o) rpt_cnt++;
      ev[s] = 1'b0;
   end

   // starts and ends just after a falling edge
   task automatic arm_run(input bit m, input int a, input int b, input int c,
                          input logic [5:0] code, input bit fin, input bit mid,
                          input bit with_sync);
      bit nul;
      mode_i = m; acnt_i = CW'(a); bcnt_i = CW'(b); ccnt_i = CW'(c);
      code_i = code; fin_ie_i = fin; mid_ie_i = mid;
      arm_i = 1'b1; sync_i = with_sync;
      @(negedge clk);
      arm_i = 1'b0; sync_i = 1'b0;
      nul = (a == 0 || b == 0 || c == 0);
      if (nul) chk(done_o == 1'b1, "R12 done after null arm", int'(done_o), 1);
      else     chk(done_o == 1'b0, "R2 done after arm", int'(done_o), 0);
      if (with_sync) chk(req_o == 1'b0, "R2 sync with arm", int'(req_o), 0);
      exp_rem  = reqs_of(m, a, b, c);
      cur_fin  = fin; cur_mid = mid; cur_code = code;
      req_cnt  = 0;
      // R9: disturb inputs after arm
      code_i   = 6'($urandom);
      fin_ie_i = 1'($urandom); mid_ie_i = 1'($urandom);
      bcnt_i   = CW'($urandom_range(1, 9));
   endtask

   task automatic do_sync(input int gap);
      bit exp_req, lst;
      int s;
      repeat (gap) @(negedge clk);
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
      exp_req = (exp_rem > 0);
      if (exp_req) chk(req_o == 1'b1, "R3 request", int'(req_o), 1);
      else         chk(req_o == 1'b0, "R11 sync after end", int'(req_o), 0);
      if (req_o) req_cnt++;
      if (exp_req) begin
         lst = (exp_rem == 1);
         chk(req_last_o == lst, "R4 last flag", int'(req_last_o), int'(lst));
         chk(done_o == lst, "R4 done", int'(done_o), int'(lst));
         s = (cyc + RPT_LAT) % 16;
         ev[s] = lst ? cur_fin : cur_mid;
         ef[s] = lst;
         ec[s] = cur_code;
         exp_rem--;
      end
   endtask

   task automatic finish_run(input int extra);
      int guard = 0;
      while (exp_rem > 0 && guard < 100) begin
         do_sync($urandom_range(0, 2));
         guard++;
      end
      repeat (extra) do_sync($urandom_range(0, 1));
      repeat (RPT_LAT + 2) @(negedge clk);
   endtask

   task automatic directed(input bit m, input int b, input int c, input bit fin,
                           input bit mid, input int exp_rpt, input string tag);
      rpt_cnt = 0;
      arm_run(m, 3, b, c, 6'h1E, fin, mid, 1'b0);
      finish_run(1);
      chk(req_cnt == reqs_of(m, 3, b, c), m ? "R5 request count" : "R4 request count",
          req_cnt, reqs_of(m, 3, b, c));
      chk(rpt_cnt == exp_rpt, tag, rpt_cnt, exp_rpt);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin ev[i] = 0; ef[i] = 0; ec[i] = '0; end
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(done_o == 1'b1 && req_o == 1'b0 && rpt_o == 1'b0, "R1 in reset",
          {done_o, req_o, rpt_o}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_o == 1'b1 && req_o == 1'b0 && req_last_o == 1'b0 && rpt_o == 1'b0,
          "R1 after reset", {done_o, req_o, rpt_o}, 3'b100);
      do_sync(0);   // R11: idle sync ignored

      // worked example: 4 arrays x 5 frames
      directed(1'b0, 4, 5, 1'b1, 1'b0, 1,  "R6 final only, array sync");
      directed(1'b0, 4, 5, 1'b0, 1'b1, 19, "R7 intermediate only, array sync");
      directed(1'b0, 4, 5, 1'b1, 1'b1, 20, "R8 both, array sync");
      directed(1'b1, 4, 5, 1'b1, 1'b0, 1,  "R6 final only, frame sync");
      directed(1'b1, 4, 5, 1'b0, 1'b1, 4,  "R7 intermediate only, frame sync");
      directed(1'b1, 4, 5, 1'b1, 1'b1, 5,  "R8 both, frame sync");
      directed(1'b0, 2, 2, 1'b0, 1'b0, 0,  "R8 no enables");
      directed(1'b0, 1, 1, 1'b0, 1'b1, 0,  "R7 single request");

      // null runs
      for (int z = 0; z < 3; z++) begin
         rpt_cnt = 0;
         arm_run(1'b0, z == 0 ? 0 : 2, z == 1 ? 0 : 2, z == 2 ? 0 : 2, 6'h05, 1, 1, 1'b0);
         finish_run(2);
         chk(req_cnt == 0, "R12 null run requests", req_cnt, 0);
         chk(rpt_cnt == 0, "R12 null run reports", rpt_cnt, 0);
      end

      // re-arm in mid-run, with a sync in the arm cycle
      arm_run(1'b0, 2, 3, 3, 6'h11, 1, 1, 1'b0);
      do_sync(0); do_sync(1);
      rpt_cnt = 0;
      arm_run(1'b1, 2, 7, 2, 6'h2A, 1, 1, 1'b1);
      finish_run(2);
      chk(req_cnt == 2, "R13 re-armed request count", req_cnt, 2);
      chk(rpt_cnt == 4, "R13 reports incl. two in flight", rpt_cnt, 4);

      // random runs
      for (int r = 0; r < 40; r++) begin
         bit m, fin, mid;
         int a, b, c, n;
         m   = 1'($urandom);
         fin = 1'($urandom); mid = 1'($urandom);
         a   = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 200);
         b   = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 4);
         c   = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 4);
         n   = reqs_of(m, a, b, c);
         rpt_cnt = 0;
         arm_run(m, a, b, c, 6'($urandom), fin, mid, 1'($urandom));
         finish_run($urandom_range(0, 2));
         chk(req_cnt == n, m ? "R5 random requests" : "R4 random requests", req_cnt, n);
         chk(rpt_cnt == rpts_of(n, fin, mid), "R8 random reports", rpt_cnt,
             rpts_of(n, fin, mid));
      end

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule